// File: doc/BRIEF.md
# Configuration Bitstream Header Stripper

This block sits between a byte source that reads a stored FPGA configuration file and the logic that shifts configuration data into a device. It consumes the file one byte per handshake, walks the header records that precede the bitstream, and forwards only the bitstream bytes. Nothing from the header reaches the output.

The header opens with a length-prefixed preamble block, followed by a two-byte chip count. Next come four text records with the tag characters 'a' to 'd'. Each text record is a tag byte, a 16-bit length and then exactly that many bytes, the last of which is a null. The payload record comes last. It is tagged 'e' and carries a 32-bit byte count, followed by that many bitstream bytes, which usually start with 0xF2. The captured count is shown on an output. When the final bitstream byte has been accepted downstream, a single-cycle completion pulse is raised. A malformed header sets a sticky error flag and halts the stream.

Top module: `bitfile_strip`

## Requirements
- R1: After synchronous reset, inReady is 1 and outValid, lenValid, hdrDone and errFlag are all 0.
- R2: Every count is big-endian. The preamble is a 16-bit count N followed by max(N,1) bytes: N-1 filler bytes and a closing byte. The preamble contents are consumed and never forwarded.
- R3: The two-byte chip count after the preamble is consumed, and its value has no effect on parsing.
- R4: The four text records in order have tag bytes 0x61, 0x62, 0x63 and 0x64. Each is followed by a 16-bit count N and then max(N,1) bytes, the last of which must be 0x00. A well-formed header leaves errFlag at 0.
- R5: If a tag byte differs from the expected value at its position, errFlag is set and stays set until reset. While it is set, inReady and outValid are 0.
- R6: If the last byte of a text record is not 0x00, errFlag is set with the same sticky, halting behaviour as R5.
- R7: The payload record has tag 0x65 and a 32-bit count. From the cycle after the last count byte is accepted, payloadLen holds that count and lenValid is 1, and both stay that way until reset.
- R8: Exactly payloadLen bytes are forwarded, unchanged and in input order. After the last one, inReady is 0 and no further byte is forwarded.
- R9: hdrDone is high for exactly one cycle. That cycle follows the acceptance of the last payload byte, or follows the capture of a zero count.
- R10: During the payload, inReady follows outReady, so downstream backpressure stalls the input and no byte is lost.
- R11: A synchronous reset in the middle of a stream returns the parser to the preamble count, and a complete file sent afterwards is parsed correctly.
- R12: outValid is never asserted before the payload count has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inByte | input | 8 | File byte from source |
| inValid | input | 1 | Source has a byte |
| inReady | output | 1 | Parser takes the byte this cycle |
| outByte | output | 8 | Bitstream byte to sink |
| outValid | output | 1 | Bitstream byte available |
| outReady | input | 1 | Sink accepts the byte |
| payloadLen | output | 32 | Captured payload byte count |
| lenValid | output | 1 | payloadLen has been captured |
| hdrDone | output | 1 | One-cycle pulse at end of payload |
| errFlag | output | 1 | Sticky header format error |

## Verification
The assertions assume that the source and sink follow the handshake: inValid and outReady are known, 0 or 1, on every clock edge, and reset is held for at least one edge before the first byte. The forwarded-byte counter in the checker also assumes that a byte counts as transferred only when outValid and outReady are both high at an edge. The bench meets these conditions. It changes every input half a cycle away from the rising edge, it asserts reset at time zero, and it keeps inValid high from one byte to the next only while it is presenting a new byte. As a result, each handshake the design sees is one the bench intended.

// File: rtl/bitfile_pkg.sv
package bitfile_pkg;
  typedef enum logic [3:0] {
    S_PLEN, S_PBODY, S_CHIP, S_TAG, S_TLEN, S_TBODY, S_ELEN, S_PAY, S_DONE, S_ERR
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic clrIdx;
    logic loadRemain;
    logic decRemain;
    logic nextTag;
    logic latchLen;
    logic setErr;
    logic fireDone;
  } strobe_t;

  localparam logic [7:0] TAG_BASE = 8'h61;
endpackage

// File: rtl/bitfile_dp.sv
module bitfile_dp
  import bitfile_pkg::*;
#(
  parameter int LEN_W = 32,
  localparam int IDX_W = $clog2(LEN_W / 8)
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  logic [7:0]       inByte,
  output logic [LEN_W-1:0] assembled,
  output logic [IDX_W-1:0] byteIdx,
  output logic [LEN_W-1:0] remain,
  output logic [2:0]       tagIdx,
  output logic [LEN_W-1:0] payloadLen,
  output logic             lenValid,
  output logic             errFlag,
  output logic             hdrDone
);
  logic [LEN_W-1:0] lenShift;

  // Count value including the byte on the bus this cycle
  assign assembled = {lenShift[LEN_W-9:0], inByte};

  always_ff @(posedge clk) begin
    if (rst) begin
      lenShift   <= '0;
      byteIdx    <= '0;
      remain     <= '0;
      tagIdx     <= '0;
      payloadLen <= '0;
      lenValid   <= 1'b0;
      errFlag    <= 1'b0;
      hdrDone    <= 1'b0;
    end else begin
      hdrDone <= stb.fireDone;
      if (stb.clrIdx) begin
        lenShift <= '0;
        byteIdx  <= '0;
      end else if (stb.shiftIn) begin
        lenShift <= assembled;
        byteIdx  <= byteIdx + 1'b1;
      end
      if (stb.loadRemain)     remain <= assembled;
      else if (stb.decRemain) remain <= remain - 1'b1;
      if (stb.nextTag) tagIdx <= tagIdx + 1'b1;
      if (stb.latchLen) begin
        payloadLen <= assembled;
        lenValid   <= 1'b1;
      end
      if (stb.setErr) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/bitfile_ctrl.sv
module bitfile_ctrl
  import bitfile_pkg::*;
#(
  parameter int LEN_W       = 32,
  parameter int SHORT_BYTES = 2,
  localparam int IDX_W      = $clog2(LEN_W / 8),
  localparam int SHORT_LAST = SHORT_BYTES - 1,
  localparam int LONG_LAST  = LEN_W / 8 - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       inByte,
  input  logic             inValid,
  input  logic             outReady,
  input  logic [LEN_W-1:0] assembled,
  input  logic [IDX_W-1:0] byteIdx,
  input  logic [LEN_W-1:0] remain,
  input  logic [2:0]       tagIdx,
  output strobe_t          stb,
  output logic             inReady,
  output logic             outValid
);
  localparam logic [2:0] TAG_LAST = 3'd4;

  phase_t state, nextState;
  logic   fire, lastBody, shortEnd, longEnd;

  assign fire     = inValid & inReady;
  assign lastBody = (remain <= LEN_W'(1));
  assign shortEnd = (byteIdx == IDX_W'(SHORT_LAST));
  assign longEnd  = (byteIdx == IDX_W'(LONG_LAST));

  always_comb begin
    stb       = '0;
    nextState = state;
    inReady   = 1'b1;
    outValid  = 1'b0;
    unique case (state)
      S_PLEN, S_TLEN: if (fire) begin
        stb.shiftIn = 1'b1;
        if (shortEnd) begin
          stb.loadRemain = 1'b1;
          stb.clrIdx     = 1'b1;
          nextState      = (state == S_PLEN) ? S_PBODY : S_TBODY;
        end
      end
      S_PBODY: if (fire) begin
        stb.decRemain = 1'b1;
        if (lastBody) nextState = S_CHIP;
      end
      S_CHIP: if (fire) begin
        stb.shiftIn = 1'b1;
        if (shortEnd) begin
          stb.clrIdx = 1'b1;
          nextState  = S_TAG;
        end
      end
      S_TAG: if (fire) begin
        if (inByte == TAG_BASE + 8'(tagIdx))
          nextState = (tagIdx == TAG_LAST) ? S_ELEN : S_TLEN;
        else begin
          stb.setErr = 1'b1;
          nextState  = S_ERR;
        end
      end
      S_TBODY: if (fire) begin
        stb.decRemain = 1'b1;
        if (lastBody) begin
          if (inByte != 8'h00) begin
            stb.setErr = 1'b1;
            nextState  = S_ERR;
          end else begin
            stb.nextTag = 1'b1;
            nextState   = S_TAG;
          end
        end
      end
      S_ELEN: if (fire) begin
        stb.shiftIn = 1'b1;
        if (longEnd) begin
          stb.latchLen   = 1'b1;
          stb.loadRemain = 1'b1;
          stb.clrIdx     = 1'b1;
          if (assembled == '0) begin
            stb.fireDone = 1'b1;
            nextState    = S_DONE;
          end else begin
            nextState = S_PAY;
          end
        end
      end
      S_PAY: begin
        inReady  = outReady;
        outValid = inValid;
        if (fire) begin
          stb.decRemain = 1'b1;
          if (remain == LEN_W'(1)) begin
            stb.fireDone = 1'b1;
            nextState    = S_DONE;
          end
        end
      end
      default: inReady = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_PLEN;
    else     state <= nextState;
  end
endmodule

// File: rtl/bitfile_strip.sv
module bitfile_strip
  import bitfile_pkg::*;
#(
  parameter int LEN_W       = 32,
  parameter int SHORT_BYTES = 2,
  localparam int IDX_W      = $clog2(LEN_W / 8)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       inByte,
  input  logic             inValid,
  output logic             inReady,
  output logic [7:0]       outByte,
  output logic             outValid,
  input  logic             outReady,
  output logic [LEN_W-1:0] payloadLen,
  output logic             lenValid,
  output logic             hdrDone,
  output logic             errFlag
);
  strobe_t          stb;
  logic [LEN_W-1:0] assembled, remain;
  logic [IDX_W-1:0] byteIdx;
  logic [2:0]       tagIdx;

  assign outByte = inByte;

  bitfile_ctrl #(.LEN_W(LEN_W), .SHORT_BYTES(SHORT_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .inByte(inByte), .inValid(inValid), .outReady(outReady),
    .assembled(assembled), .byteIdx(byteIdx), .remain(remain), .tagIdx(tagIdx),
    .stb(stb), .inReady(inReady), .outValid(outValid)
  );

  bitfile_dp #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .inByte(inByte), .assembled(assembled),
    .byteIdx(byteIdx), .remain(remain), .tagIdx(tagIdx), .payloadLen(payloadLen),
    .lenValid(lenValid), .errFlag(errFlag), .hdrDone(hdrDone)
  );
endmodule

// File: rtl/bitfile_strip_chk.sv
module bitfile_strip_chk #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [LEN_W-1:0] payloadLen,
  input logic             lenValid,
  input logic             hdrDone,
  input logic             errFlag
);
  logic [LEN_W-1:0] fwdCnt;

  always_ff @(posedge clk) begin
    if (rst) fwdCnt <= '0;
    else if (outValid && outReady) fwdCnt <= fwdCnt + 1'b1;
  end

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);
  p_err_halts_r5: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> (!inReady && !outValid));
  p_len_held_r7: assert property (@(posedge clk) disable iff (rst)
    lenValid |=> (lenValid && $stable(payloadLen)));
  p_fwd_bound_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (fwdCnt < payloadLen));
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    hdrDone |=> !hdrDone);
  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);
  p_no_early_out_r12: assert property (@(posedge clk) disable iff (rst)
    outValid |-> lenValid);
endmodule

bind bitfile_strip bitfile_strip_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .outValid(outValid), .outReady(outReady),
  .payloadLen(payloadLen), .lenValid(lenValid), .hdrDone(hdrDone), .errFlag(errFlag)
);

// File: tb/bitfile_strip_test.sv
`timescale 1ns/1ps
module bitfile_strip_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  inByte = 8'h00;
  logic        inValid = 1'b0;
  logic        outReady = 1'b1;
  logic        inReady, outValid, lenValid, hdrDone, errFlag;
  logic [7:0]  outByte;
  logic [31:0] payloadLen;

  bitfile_strip uut (
    .clk(clk), .rst(rst), .inByte(inByte), .inValid(inValid), .inReady(inReady),
    .outByte(outByte), .outValid(outValid), .outReady(outReady),
    .payloadLen(payloadLen), .lenValid(lenValid), .hdrDone(hdrDone), .errFlag(errFlag)
  );

  always #4 clk = ~clk;

  // Nominal file: preamble N=3, chips=5, text records a..d, payload of 4 bytes
  localparam logic [7:0] NOMINAL [0:35] = '{
    8'h00, 8'h03, 8'hAA, 8'hBB, 8'h00,
    8'h00, 8'h05,
    8'h61, 8'h00, 8'h03, 8'h78, 8'h79, 8'h00,
    8'h62, 8'h00, 8'h02, 8'h6B, 8'h00,
    8'h63, 8'h00, 8'h01, 8'h00,
    8'h64, 8'h00, 8'h02, 8'h7A, 8'h00,
    8'h65, 8'h00, 8'h00, 8'h00, 8'h04,
    8'hF2, 8'h11, 8'h22, 8'h33
  };
  localparam logic [7:0] NOM_PAY [0:3] = '{8'hF2, 8'h11, 8'h22, 8'h33};

  logic [7:0] strm [0:1023];
  logic [7:0] got  [0:1023];
  int strmLen, gotLen, leak, stallBad, doneCount, cyc;
  int checks = 0;
  int failures = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (hdrDone) doneCount <= doneCount + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] payByte(int k);
    return (k == 0) ? 8'hF2 : 8'(k * 13 + 1);
  endfunction

  task automatic push(input logic [7:0] b);
    strm[strmLen] = b;
    strmLen++;
  endtask

  task automatic build(input int pre, input int chips, input int badTag, input int badNull, input int payN);
    strmLen = 0;
    push(8'(pre >> 8)); push(8'(pre));
    for (int i = 0; i < pre - 1; i++) push(8'h5A);
    push(8'h00);
    push(8'(chips >> 8)); push(8'(chips));
    for (int t = 0; t < 4; t++) begin
      push((t == badTag) ? 8'h71 : 8'(8'h61 + t));
      push(8'h00); push(8'h03);
      push(8'h41); push(8'h42);
      push((t == badNull) ? 8'h41 : 8'h00);
    end
    push(8'h65);
    push(8'(payN >> 24)); push(8'(payN >> 16)); push(8'(payN >> 8)); push(8'(payN));
    for (int k = 0; k < payN; k++) push(payByte(k));
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; outReady = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    gotLen = 0; leak = 0; stallBad = 0; doneCount = 0;
  endtask

  // Send strm[0..n-1]; stops if a byte is not taken within 40 cycles
  task automatic sendStream(input int n, input bit stall);
    for (int i = 0; i < n; i++) begin
      bit taken = 1'b0;
      for (int w = 0; w < 40 && !taken; w++) begin
        @(negedge clk);
        inValid  = 1'b1;
        inByte   = strm[i];
        outReady = stall ? ((cyc % 3) != 0) : 1'b1;
        #1;
        if (outValid && !lenValid) leak++;
        if (outValid && !outReady && inReady) stallBad++;
        if (inReady) begin
          if (outValid && outReady) begin
            got[gotLen] = outByte;
            gotLen++;
          end
          @(posedge clk);
          taken = 1'b1;
        end
      end
      if (!taken) break;
    end
    @(negedge clk);
    inValid  = 1'b0;
    outReady = 1'b1;
  endtask

  task automatic checkPayload(input int n, input bit nominal, input string req);
    int bad = 0;
    chk(gotLen == n, req, gotLen, n);
    for (int k = 0; k < n && k < gotLen; k++)
      if (got[k] != (nominal ? NOM_PAY[k] : payByte(k))) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    cyc = 0;
    doReset();
    #1;
    // R1 reset state
    chk(inReady == 1'b1 && outValid == 1'b0, "R1", {inReady, outValid}, 2'b10);
    chk(!lenValid && !hdrDone && !errFlag, "R1", {lenValid, hdrDone, errFlag}, 0);

    // Nominal table walked in one loop (R2, R3 chips=5, R4, R7, R8, R9, R12)
    strmLen = 0;
    for (int i = 0; i < 36; i++) push(NOMINAL[i]);
    sendStream(35, 1'b0);
    chk(lenValid && payloadLen == 32'd4, "R7", payloadLen, 4);
    sendStream(36, 1'b0); // resend is harmless only if reset; so redo cleanly below
    doReset();
    strmLen = 0;
    for (int i = 0; i < 36; i++) push(NOMINAL[i]);
    sendStream(36, 1'b0);
    #1;
    // sendStream ends at the negedge right after the last accepting edge
    chk(hdrDone == 1'b1, "R9", hdrDone, 1);
    checkPayload(4, 1'b1, "R8");
    chk(errFlag == 1'b0, "R4", errFlag, 0);
    chk(leak == 0, "R12", leak, 0);
    chk(lenValid && payloadLen == 32'd4, "R7", payloadLen, 4);
    repeat (3) @(negedge clk);
    #1;
    chk(doneCount == 1, "R9", doneCount, 1);
    chk(inReady == 1'b0, "R8", inReady, 0);
    strm[0] = 8'h99;
    sendStream(1, 1'b0);
    chk(gotLen == 4, "R8", gotLen, 4);

    // Wide counts, backpressure (R2 preamble 0x0102, R3 chips 0x0300, R7 0x103, R10)
    doReset();
    build(258, 16'h0300, -1, -1, 259);
    sendStream(strmLen, 1'b1);
    chk(payloadLen == 32'd259, "R7", payloadLen, 259);
    checkPayload(259, 1'b0, "R10");
    chk(stallBad == 0, "R10", stallBad, 0);
    chk(errFlag == 1'b0, "R2", errFlag, 0);

    // Bad tag on second record (R5)
    doReset();
    build(3, 1, 1, -1, 4);
    sendStream(strmLen, 1'b0);
    repeat (2) @(negedge clk);
    #1;
    chk(errFlag == 1'b1, "R5", errFlag, 1);
    chk(inReady == 1'b0 && outValid == 1'b0, "R5", {inReady, outValid}, 0);
    chk(gotLen == 0 && !lenValid, "R5", gotLen, 0);

    // Missing null on third record (R6)
    doReset();
    build(3, 1, -1, 2, 4);
    sendStream(strmLen, 1'b0);
    #1;
    chk(errFlag == 1'b1 && inReady == 1'b0, "R6", {errFlag, inReady}, 2'b10);
    chk(gotLen == 0, "R6", gotLen, 0);

    // Reset mid-stream (R11)
    doReset();
    build(3, 1, -1, -1, 6);
    sendStream(12, 1'b0);
    doReset();
    #1;
    chk(inReady && !lenValid && !errFlag, "R11", {inReady, lenValid, errFlag}, 3'b100);
    sendStream(strmLen, 1'b0);
    checkPayload(6, 1'b0, "R11");

    // Zero-length payload (R9)
    doReset();
    build(1, 0, -1, -1, 0);
    sendStream(strmLen, 1'b0);
    #1;
    chk(hdrDone == 1'b1, "R9", hdrDone, 1);
    chk(lenValid && payloadLen == 0, "R9", payloadLen, 0);
    repeat (2) @(negedge clk);
    chk(doneCount == 1 && gotLen == 0, "R9", doneCount, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule